// File: doc/BRIEF.md
# SDRAM Power-Up Sequencer

This block brings a single-data-rate SDRAM from power-up to a usable state before the main controller may send it anything. Once reset is released, it turns on the clock-enable, on-die-termination and active-low device-reset lines. It then holds the bus idle for a long settle period. After that it issues a fixed series of single-cycle commands on a single-phase command interface: precharge-all, a mode load that resets the DLL, precharge-all again, two auto-refreshes, and a final mode load without the DLL-reset bit. Each command is separated from the next by a programmed wait.

When the last wait has run out, the block raises `init_done_o` and hands the command, address and bank outputs to the main controller through a combinational mux. The host inputs have no effect until then. All wait lengths and the mode-word fields are parameters. Their defaults match a part run at CAS latency 2 and burst length 1: a 20000-cycle settle, a 200-cycle mode-load wait and a 4-cycle refresh wait. Asserting reset at any time restarts the whole sequence.

Top module: `sdram_init_seq`

## Requirements
- R1: While `rst_ni` is low, all command bits, the address, the bank, `dfi_cke_o`, `dfi_odt_o`, `dfi_reset_n_o` and `init_done_o` are 0. The host inputs have no effect on them.
- R2: From the first clock edge after reset release, `dfi_cke_o`, `dfi_odt_o` and `dfi_reset_n_o` are 1 and stay 1. No command is issued on edges 1 through T_POWER.
- R3: `dfi_cmd_o` bit 0 is chip select, bit 1 is WE, bit 2 is CAS and bit 3 is RAS, with 1 meaning asserted. Each sequencer command lasts one cycle and is followed by at least one all-zero cycle. Before `init_done_o`, address and bank are 0 whenever no command is present.
- R4: The first command is precharge-all (`4'b1011`, address `0x400`, bank 0) and appears after edge T_POWER+1 counted from reset release.
- R5: A DLL-reset mode load (`4'b1111`, address `0x120`, bank 0) follows the first precharge-all 2 cycles later.
- R6: A second precharge-all follows the DLL-reset mode load T_MRD+1 cycles later.
- R7: Two auto-refreshes (`4'b1101`, address 0, bank 0) follow. The first comes 2 cycles after the second precharge-all, and the second comes T_RFC+1 cycles after the first.
- R8: A final mode load (`4'b1111`, address `0x020`, bank 0) follows the second refresh T_RFC+1 cycles later. No other sequencer command is issued.
- R9: `init_done_o` rises T_MRD+1 cycles after the final mode load and stays high until reset.
- R10: While `init_done_o` is 0, the host inputs never reach the outputs. Once it is 1, `dfi_cmd_o`, `dfi_addr_o` and `dfi_bank_o` equal the host inputs in the same cycle.
- R11: Asserting reset mid-sequence aborts it. After release, the sequence restarts from the settle wait with the same timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| host_cmd_i | input | 4 | Main controller command strobes (same bit order as dfi_cmd_o) |
| host_addr_i | input | ADDR_W | Main controller address |
| host_bank_i | input | BANK_W | Main controller bank |
| dfi_cmd_o | output | 4 | Command strobes: bit0 CS, bit1 WE, bit2 CAS, bit3 RAS |
| dfi_addr_o | output | ADDR_W | Address to memory |
| dfi_bank_o | output | BANK_W | Bank address to memory |
| dfi_cke_o | output | 1 | Clock enable |
| dfi_odt_o | output | 1 | On-die termination enable |
| dfi_reset_n_o | output | 1 | Memory reset, active low |
| init_done_o | output | 1 | Sequence complete; host owns the interface |

## Verification
Every sequencer output is registered state, so command k appears on the outputs after the edge the schedule gives: edge T_POWER+1 for the first, then 1 + (wait after the previous command) for each later one. `init_done_o` comes T_MRD+1 edges after the last command. The bench computes these edge numbers from the parameters and queues each command with its cycle. A monitor counts edges since reset release, samples on the falling clock and compares every non-idle command against the head of the queue, including its cycle. The host pass-through is combinational, so it is checked in the same cycle that the host inputs change.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;
  // strobe positions in the command vector
  localparam int unsigned CS_BIT  = 0;
  localparam int unsigned WE_BIT  = 1;
  localparam int unsigned CAS_BIT = 2;
  localparam int unsigned RAS_BIT = 3;

  localparam logic [3:0] CMD_NOP  = 4'b0000;
  localparam logic [3:0] CMD_PREA = (4'b1 << RAS_BIT) | (4'b1 << WE_BIT) | (4'b1 << CS_BIT);
  localparam logic [3:0] CMD_REF  = (4'b1 << RAS_BIT) | (4'b1 << CAS_BIT) | (4'b1 << CS_BIT);
  localparam logic [3:0] CMD_MRS  = (4'b1 << RAS_BIT) | (4'b1 << CAS_BIT) | (4'b1 << WE_BIT) | (4'b1 << CS_BIT);

  localparam int unsigned NUM_STEPS = 6;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_POWER,
    ST_ISSUE,
    ST_WAIT,
    ST_DONE
  } seq_state_e;
endpackage

// File: rtl/sdram_init_timer.sv
module sdram_init_timer #(
  parameter int unsigned CNT_W = 15
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             zero_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= load_val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

  p_timer_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> cnt_q == $past(load_val_i));
  p_timer_floor_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && zero_o) |=> zero_o);
endmodule

// File: rtl/sdram_init_fsm.sv
module sdram_init_fsm
  import sdram_init_pkg::*;
#(
  parameter int unsigned T_POWER = 20000,
  parameter int unsigned T_MRD   = 200,
  parameter int unsigned T_RFC   = 4,
  parameter int unsigned ADDR_W  = 13,
  parameter int unsigned BANK_W  = 2,
  parameter int unsigned CNT_W   = 15,
  parameter int unsigned CAS_LAT = 2,
  parameter int unsigned BL_CODE = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              zero_i,
  output logic              load_o,
  output logic [CNT_W-1:0]  load_val_o,
  output logic [3:0]        seq_cmd_o,
  output logic [ADDR_W-1:0] seq_addr_o,
  output logic [BANK_W-1:0] seq_bank_o,
  output logic              ctl_on_o,
  output logic              done_o
);
  localparam logic [ADDR_W-1:0] MODE_RUN = ADDR_W'((CAS_LAT << 4) | BL_CODE);
  localparam logic [ADDR_W-1:0] MODE_DLL = MODE_RUN | ADDR_W'(1 << 8);
  localparam logic [ADDR_W-1:0] AP_ADDR  = ADDR_W'(1 << 10);
  localparam logic [CNT_W-1:0]  LD_POWER = CNT_W'(T_POWER - 1);
  localparam logic [CNT_W-1:0]  LD_MRD   = CNT_W'(T_MRD - 1);
  localparam logic [CNT_W-1:0]  LD_RFC   = CNT_W'(T_RFC - 1);
  localparam logic [CNT_W-1:0]  LD_GAP   = '0;  // single NOP between back-to-back commands
  localparam logic [2:0]        LAST_STEP = 3'(NUM_STEPS - 1);

  seq_state_e state_q, state_d;
  logic [2:0] step_q, step_d;

  logic [3:0]        step_cmd;
  logic [ADDR_W-1:0] step_addr;
  logic [CNT_W-1:0]  step_wait;

  always_comb begin
    unique case (step_q)
      3'd0:    begin step_cmd = CMD_PREA; step_addr = AP_ADDR;  step_wait = LD_GAP; end
      3'd1:    begin step_cmd = CMD_MRS;  step_addr = MODE_DLL; step_wait = LD_MRD; end
      3'd2:    begin step_cmd = CMD_PREA; step_addr = AP_ADDR;  step_wait = LD_GAP; end
      3'd3:    begin step_cmd = CMD_REF;  step_addr = '0;       step_wait = LD_RFC; end
      3'd4:    begin step_cmd = CMD_REF;  step_addr = '0;       step_wait = LD_RFC; end
      default: begin step_cmd = CMD_MRS;  step_addr = MODE_RUN; step_wait = LD_MRD; end
    endcase
  end

  always_comb begin
    state_d    = state_q;
    step_d     = step_q;
    load_o     = 1'b0;
    load_val_o = step_wait;
    unique case (state_q)
      ST_IDLE: begin
        state_d    = ST_POWER;
        load_o     = 1'b1;
        load_val_o = LD_POWER;
      end
      ST_POWER: if (zero_i) state_d = ST_ISSUE;
      ST_ISSUE: begin
        load_o  = 1'b1;
        state_d = ST_WAIT;
      end
      ST_WAIT: if (zero_i) begin
        if (step_q == LAST_STEP) state_d = ST_DONE;
        else begin
          state_d = ST_ISSUE;
          step_d  = step_q + 3'd1;
        end
      end
      default: state_d = ST_DONE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      step_q  <= '0;
    end else begin
      state_q <= state_d;
      step_q  <= step_d;
    end
  end

  assign seq_cmd_o  = (state_q == ST_ISSUE) ? step_cmd  : CMD_NOP;
  assign seq_addr_o = (state_q == ST_ISSUE) ? step_addr : '0;
  assign seq_bank_o = '0;
  assign ctl_on_o   = (state_q != ST_IDLE);
  assign done_o     = (state_q == ST_DONE);

  p_pulse_single_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seq_cmd_o != CMD_NOP) |=> (seq_cmd_o == CMD_NOP));
  p_cs_with_cmd_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seq_cmd_o != CMD_NOP) |-> seq_cmd_o[CS_BIT]);
  p_ctl_sticky_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_on_o |=> ctl_on_o);
  p_done_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> done_o);
  p_done_after_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(seq_cmd_o) == CMD_NOP);
endmodule

// File: rtl/sdram_init_mux.sv
module sdram_init_mux #(
  parameter int unsigned ADDR_W = 13,
  parameter int unsigned BANK_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              init_done_i,
  input  logic [3:0]        seq_cmd_i,
  input  logic [ADDR_W-1:0] seq_addr_i,
  input  logic [BANK_W-1:0] seq_bank_i,
  input  logic [3:0]        host_cmd_i,
  input  logic [ADDR_W-1:0] host_addr_i,
  input  logic [BANK_W-1:0] host_bank_i,
  output logic [3:0]        dfi_cmd_o,
  output logic [ADDR_W-1:0] dfi_addr_o,
  output logic [BANK_W-1:0] dfi_bank_o
);
  always_comb begin
    if (init_done_i) begin
      dfi_cmd_o  = host_cmd_i;
      dfi_addr_o = host_addr_i;
      dfi_bank_o = host_bank_i;
    end else begin
      dfi_cmd_o  = seq_cmd_i;
      dfi_addr_o = seq_addr_i;
      dfi_bank_o = seq_bank_i;
    end
  end

  p_host_blocked_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !init_done_i |-> (dfi_cmd_o == seq_cmd_i && dfi_addr_o == seq_addr_i));
  p_host_owns_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_done_i |-> (dfi_cmd_o == host_cmd_i && dfi_bank_o == host_bank_i));
endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
  import sdram_init_pkg::*;
#(
  parameter int unsigned T_POWER = 20000,
  parameter int unsigned T_MRD   = 200,
  parameter int unsigned T_RFC   = 4,
  parameter int unsigned ADDR_W  = 13,
  parameter int unsigned BANK_W  = 2,
  parameter int unsigned CAS_LAT = 2,
  parameter int unsigned BL_CODE = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [3:0]        host_cmd_i,
  input  logic [ADDR_W-1:0] host_addr_i,
  input  logic [BANK_W-1:0] host_bank_i,
  output logic [3:0]        dfi_cmd_o,
  output logic [ADDR_W-1:0] dfi_addr_o,
  output logic [BANK_W-1:0] dfi_bank_o,
  output logic              dfi_cke_o,
  output logic              dfi_odt_o,
  output logic              dfi_reset_n_o,
  output logic              init_done_o
);
  localparam int unsigned MAX_A = (T_POWER > T_MRD) ? T_POWER : T_MRD;
  localparam int unsigned MAX_T = (MAX_A > T_RFC) ? MAX_A : T_RFC;
  localparam int unsigned CNT_W = $clog2(MAX_T + 1);

  logic              load;
  logic [CNT_W-1:0]  load_val;
  logic              zero;
  logic [3:0]        seq_cmd;
  logic [ADDR_W-1:0] seq_addr;
  logic [BANK_W-1:0] seq_bank;
  logic              ctl_on;
  logic              done;

  sdram_init_timer #(.CNT_W(CNT_W)) i_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .load_val_i (load_val),
    .zero_o     (zero)
  );

  sdram_init_fsm #(
    .T_POWER (T_POWER),
    .T_MRD   (T_MRD),
    .T_RFC   (T_RFC),
    .ADDR_W  (ADDR_W),
    .BANK_W  (BANK_W),
    .CNT_W   (CNT_W),
    .CAS_LAT (CAS_LAT),
    .BL_CODE (BL_CODE)
  ) i_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .zero_i     (zero),
    .load_o     (load),
    .load_val_o (load_val),
    .seq_cmd_o  (seq_cmd),
    .seq_addr_o (seq_addr),
    .seq_bank_o (seq_bank),
    .ctl_on_o   (ctl_on),
    .done_o     (done)
  );

  sdram_init_mux #(.ADDR_W(ADDR_W), .BANK_W(BANK_W)) i_mux (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .init_done_i (done),
    .seq_cmd_i   (seq_cmd),
    .seq_addr_i  (seq_addr),
    .seq_bank_i  (seq_bank),
    .host_cmd_i  (host_cmd_i),
    .host_addr_i (host_addr_i),
    .host_bank_i (host_bank_i),
    .dfi_cmd_o   (dfi_cmd_o),
    .dfi_addr_o  (dfi_addr_o),
    .dfi_bank_o  (dfi_bank_o)
  );

  assign dfi_cke_o     = ctl_on;
  assign dfi_odt_o     = ctl_on;
  assign dfi_reset_n_o = ctl_on;
  assign init_done_o   = done;

  p_done_needs_ctl_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_done_o |-> (dfi_cke_o && dfi_reset_n_o));
endmodule

// File: tb/test_sdram_init_seq.sv
module test_sdram_init_seq;
  localparam int unsigned TP = 50;
  localparam int unsigned TM = 20;
  localparam int unsigned TR = 4;
  localparam int unsigned AW = 13;
  localparam int unsigned BW = 2;

  localparam logic [3:0] PREA = 4'b1011;
  localparam logic [3:0] REFR = 4'b1101;
  localparam logic [3:0] MODE = 4'b1111;

  typedef struct {
    logic [3:0]    cmd;
    logic [AW-1:0] addr;
    logic [BW-1:0] bank;
    int            cyc;
    string         req;
  } exp_t;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [3:0]    host_cmd_i = 4'b0110;
  logic [AW-1:0] host_addr_i = 13'h1abc;
  logic [BW-1:0] host_bank_i = 2'd3;
  logic [3:0]    dfi_cmd_o;
  logic [AW-1:0] dfi_addr_o;
  logic [BW-1:0] dfi_bank_o;
  logic          dfi_cke_o, dfi_odt_o, dfi_reset_n_o, init_done_o;

  int   cyc;
  int   errors = 0;
  int   checks = 0;
  int   exp_done_cyc;
  bit   done_seen;
  exp_t exp_q[$];

  always #4 clk_i = ~clk_i;

  always @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) cyc <= 0;
    else         cyc <= cyc + 1;

  sdram_init_seq #(.T_POWER(TP), .T_MRD(TM), .T_RFC(TR), .ADDR_W(AW), .BANK_W(BW)) i_sdram_init_seq (
    .clk_i, .rst_ni, .host_cmd_i, .host_addr_i, .host_bank_i,
    .dfi_cmd_o, .dfi_addr_o, .dfi_bank_o, .dfi_cke_o, .dfi_odt_o,
    .dfi_reset_n_o, .init_done_o
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp_v);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h (cycle %0d)", req, act, exp_v, cyc);
    end
  endtask

  task automatic push_item(input logic [3:0] c, input logic [AW-1:0] a, input int at, input string r);
    exp_t e;
    e.cmd = c; e.addr = a; e.bank = '0; e.cyc = at; e.req = r;
    exp_q.push_back(e);
  endtask

  // driver: expected schedule, computed from the requirement timings
  task automatic push_sequence();
    int c0, c1, c2, c3, c4, c5;
    c0 = TP + 1;
    c1 = c0 + 2;
    c2 = c1 + TM + 1;
    c3 = c2 + 2;
    c4 = c3 + TR + 1;
    c5 = c4 + TR + 1;
    exp_q.delete();
    done_seen = 1'b0;
    push_item(PREA, 13'h400, c0, "R4");
    push_item(MODE, 13'h120, c1, "R5");
    push_item(PREA, 13'h400, c2, "R6");
    push_item(REFR, 13'h000, c3, "R7");
    push_item(REFR, 13'h000, c4, "R7");
    push_item(MODE, 13'h020, c5, "R8");
    exp_done_cyc = c5 + TM + 1;
  endtask

  task automatic check_reset_state();
    chk(dfi_cmd_o == 4'b0 && dfi_addr_o == '0 && dfi_bank_o == '0, "R1",
        {dfi_cmd_o, dfi_bank_o, dfi_addr_o}, 32'h0);
    chk(!dfi_cke_o && !dfi_odt_o && !dfi_reset_n_o && !init_done_o, "R1",
        {dfi_cke_o, dfi_odt_o, dfi_reset_n_o, init_done_o}, 32'h0);
  endtask

  task automatic monitor();
    exp_t e;
    forever begin
      @(negedge clk_i);
      if (rst_ni) begin
        if (!init_done_o) begin
          chk(dfi_cke_o && dfi_odt_o && dfi_reset_n_o, "R2",
              {dfi_cke_o, dfi_odt_o, dfi_reset_n_o}, 32'h7);
          if (dfi_cmd_o != 4'b0) begin
            if (exp_q.size() == 0) chk(1'b0, "R3 unexpected command", dfi_cmd_o, 32'h0);
            else begin
              e = exp_q.pop_front();
              chk(dfi_cmd_o == e.cmd, e.req, dfi_cmd_o, e.cmd);
              chk(dfi_addr_o == e.addr && dfi_bank_o == e.bank, e.req,
                  {dfi_bank_o, dfi_addr_o}, {e.bank, e.addr});
              chk(cyc == e.cyc, {e.req, " timing"}, cyc, e.cyc);
            end
          end else begin
            chk(dfi_addr_o == '0 && dfi_bank_o == '0, "R3 idle bus",
                {dfi_bank_o, dfi_addr_o}, 32'h0);
          end
        end
        if (init_done_o && !done_seen) begin
          done_seen = 1'b1;
          chk(cyc == exp_done_cyc, "R9 done timing", cyc, exp_done_cyc);
        end else if (!init_done_o && done_seen) begin
          chk(1'b0, "R9 done dropped", 32'h0, 32'h1);
        end
      end
    end
  endtask

  task automatic main();
    repeat (3) @(negedge clk_i);
    check_reset_state();                      // R1 with host driving
    push_sequence();
    rst_ni = 1'b1;
    wait (cyc == TP + 1 + 2 + 3);             // mid-wait after DLL-reset mode load
    @(negedge clk_i);
    rst_ni = 1'b0;                            // R11 abort
    push_sequence();
    @(negedge clk_i);
    check_reset_state();
    @(negedge clk_i);
    rst_ni = 1'b1;
    wait (cyc == TP + 1);
    @(negedge clk_i);
    chk(dfi_cmd_o == PREA, "R11 restart", dfi_cmd_o, PREA);
    wait (cyc == exp_done_cyc + 5);
    @(negedge clk_i);
    chk(exp_q.size() == 0, "R8 all commands issued", exp_q.size(), 32'h0);
    chk(done_seen && init_done_o, "R9 done held", init_done_o, 32'h1);
    // R10 pass-through once done
    @(posedge clk_i); #1;
    host_cmd_i = 4'b0101; host_addr_i = 13'h0f0f; host_bank_i = 2'd2;
    @(negedge clk_i);
    chk(dfi_cmd_o == 4'b0101 && dfi_addr_o == 13'h0f0f && dfi_bank_o == 2'd2, "R10",
        {dfi_cmd_o, dfi_bank_o, dfi_addr_o}, {4'b0101, 2'd2, 13'h0f0f});
    @(posedge clk_i); #1;
    host_cmd_i = 4'b1011; host_addr_i = 13'h1234; host_bank_i = 2'd1;
    @(negedge clk_i);
    chk(dfi_cmd_o == 4'b1011 && dfi_addr_o == 13'h1234 && dfi_bank_o == 2'd1, "R10",
        {dfi_cmd_o, dfi_bank_o, dfi_addr_o}, {4'b1011, 2'd1, 13'h1234});
    chk(dfi_cke_o && dfi_odt_o && dfi_reset_n_o, "R2 after done",
        {dfi_cke_o, dfi_odt_o, dfi_reset_n_o}, 32'h7);
  endtask

  initial begin
    fork
      monitor();
      main();
      begin
        repeat (200000) @(posedge clk_i);
        chk(1'b0, "watchdog", cyc, 32'h0);
      end
    join_any
    disable fork;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule